// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the 16-bit management registers of an Ethernet-style PHY behind a plain parallel access port (address, write data, write strobe, read strobe, read data). It is meant to sit behind whatever serial management front end the chip uses. The bits follow several access policies. Some are plain read/write. Some are read-only or hard-wired. Some latch an event until software reads them, some clear when read, one clears itself, and some load their reset value from strap pins.

The basic control register at address 0x00 drives the PHY's control outputs: loopback, isolate, power down, auto-negotiation enable, and the forced speed and duplex. It also starts a timed software reset. That reset returns the control register to its defaults and leaves the vendor registers alone. A status register at 0x01 latches the link, remote-fault and negotiation-done event inputs. A constant identifier sits at 0x02. The vendor registers are a scratch word at 0x10 and a clear-on-read event word at 0x11.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After a hardware reset with both strap pins high, register 0x00 reads 0x3000, `ctl_soft_reset` is 0, `ctl_aneg_en` is 1, and loopback, isolate, power down and both forced outputs are 0.
- R2: Speed select (0x00 bit 13) and auto-negotiation enable (0x00 bit 12) take the values that `strap_speed` and `strap_aneg` hold in the last cycle of hardware reset. Later changes on the strap pins do not affect them.
- R3: In register 0x00, loopback (bit 14), speed (bit 13), auto-negotiation enable (bit 12), power down (bit 11), isolate (bit 10) and duplex (bit 8) are read/write. Bits 9 and 7..0 always read 0.
- R4: Writing 0x00 with bit 15 set starts a software reset that lasts RST_CYCLES clock edges. Bit 15 and `ctl_soft_reset` read 1 throughout. During the reset, writes to 0x00 are ignored. When it ends, bit 15 reads 0 and every control bit is back at its default, with the strap bits reloaded from the values captured at hardware reset.
- R5: The software reset leaves the vendor scratch register (0x10) and the vendor event register (0x11) unchanged.
- R6: `ctl_loopback`, `ctl_isolate` and `ctl_aneg_en` follow their register bits. `ctl_speed100` equals bit 13 and `ctl_full_duplex` equals bit 8 while bit 12 is 0. Both forced outputs are 0 while bit 12 is 1.
- R7: `ctl_power_down` equals bit 11 OR NOT `pwdn_pin_n`, combinationally. A low level on the pin also sets bit 11, and the bit stays 1 after the pin is released. Register accesses keep working during power down.
- R8: Register 0x01 reads as follows. Bits 15..12 are the constant 0111 and bit 0 is the constant 1. Bit 5 shows the live `aneg_done` input. Bit 4 is the latched-high remote fault. Bit 2 is the latched-low link. All other bits read 0. Writes to 0x01 have no effect.
- R9: The latched-high bit is set by a high `remote_fault` and stays 1 until the register is read. The latched-low bit is cleared by a low `link_up` and stays 0 until the register is read. A read returns the held value and then reloads the bit from the input in that same cycle, so an event that coincides with the read is kept.
- R10: Register 0x11 bits 3..0 capture the `vend_evt` pulses and read 0 in bits 15..4. A read returns the held bits and clears them, except for events present in the read cycle, which are kept.
- R11: Register 0x02 always reads the parameter ID_WORD. Writes to it have no effect.
- R12: A read from any address other than 0x00, 0x01, 0x02, 0x10 and 0x11 returns 0x0000 and clears no latched or clear-on-read bit.
- R13: `rd_data` takes the selected register's value at the clock edge where `rd_en` is sampled high, so it is valid one cycle after the strobe. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset; straps sampled while high |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| strap_speed | input | 1 | Strap default for speed select |
| strap_aneg | input | 1 | Strap default for auto-negotiation enable |
| pwdn_pin_n | input | 1 | Active-low external power-down request |
| link_up | input | 1 | Link status event (latched low) |
| remote_fault | input | 1 | Remote fault event (latched high) |
| aneg_done | input | 1 | Negotiation-complete level, reported live |
| vend_evt | input | VEVT_W | Vendor event pulses (clear-on-read) |
| ctl_soft_reset | output | 1 | Software reset in progress |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_isolate | output | 1 | Isolate enable |
| ctl_power_down | output | 1 | Power-down request |
| ctl_aneg_en | output | 1 | Auto-negotiation enable |
| ctl_speed100 | output | 1 | Forced 100 Mbps when negotiation is off |
| ctl_full_duplex | output | 1 | Forced full duplex when negotiation is off |

## Verification
Each latched bit gets four patterns. A single-cycle pulse followed by two reads shows that the value is held and then released. A steady input shows the reload path. A pulse timed onto the read edge shows that a coinciding event survives the clear. An unmapped read in between shows that side effects are tied to the address. The control word is written with different mixes of auto-negotiation, speed and duplex, which tells the forced-mode gating apart from plain bit mirroring. The software reset is probed on its last busy edge and on the first edge after it, with a write and a changed strap pin in between. This separates a correct cycle count, write blocking and strap reload from off-by-one or live-strap variants.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int A_CTL  = 'h00;
    localparam int A_STAT = 'h01;
    localparam int A_ID   = 'h02;
    localparam int A_SCR  = 'h10;
    localparam int A_VEVT = 'h11;

    localparam int B_SRST  = 15;
    localparam int B_LOOP  = 14;
    localparam int B_SPEED = 13;
    localparam int B_ANEG  = 12;
    localparam int B_PDN   = 11;
    localparam int B_ISO   = 10;
    localparam int B_DUP   = 8;

    localparam logic [3:0] STAT_CAP = 4'b0111;

    typedef struct packed {
        logic loopback;
        logic speed100;
        logic aneg_en;
        logic pdown;
        logic isolate;
        logic duplex;
    } ctl_fields_t;

    typedef struct packed {
        logic aneg_done;
        logic rfault_lh;
        logic link_ll;
    } stat_fields_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_STAT,
        SEL_ID,
        SEL_SCR,
        SEL_VEVT
    } rsel_e;

    function automatic ctl_fields_t ctl_from_word(input logic [15:0] w);
        ctl_fields_t f;
        f.loopback = w[B_LOOP];
        f.speed100 = w[B_SPEED];
        f.aneg_en  = w[B_ANEG];
        f.pdown    = w[B_PDN];
        f.isolate  = w[B_ISO];
        f.duplex   = w[B_DUP];
        return f;
    endfunction

    function automatic logic [15:0] ctl_to_word(input logic busy, input ctl_fields_t f);
        logic [15:0] w;
        w          = '0;
        w[B_SRST]  = busy;
        w[B_LOOP]  = f.loopback;
        w[B_SPEED] = f.speed100;
        w[B_ANEG]  = f.aneg_en;
        w[B_PDN]   = f.pdown;
        w[B_ISO]   = f.isolate;
        w[B_DUP]   = f.duplex;
        return w;
    endfunction

    function automatic logic [15:0] stat_to_word(input stat_fields_t s);
        logic [15:0] w;
        w         = '0;
        w[15:12]  = STAT_CAP;
        w[5]      = s.aneg_done;
        w[4]      = s.rfault_lh;
        w[2]      = s.link_ll;
        w[0]      = 1'b1;
        return w;
    endfunction

    function automatic ctl_fields_t ctl_defaults(input logic spd, input logic an, input logic pd);
        ctl_fields_t f;
        f          = '0;
        f.speed100 = spd;
        f.aneg_en  = an;
        f.pdown    = pd;
        return f;
    endfunction

endpackage

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
    import phy_mgmt_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic        wr_srst,
    input  ctl_fields_t wr_fields,
    input  logic        strap_speed,
    input  logic        strap_aneg,
    input  logic        pin_pd,
    output ctl_fields_t fields,
    output logic        busy
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          strap_spd_q;
    logic          strap_an_q;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_spd_q <= strap_speed;
            strap_an_q  <= strap_aneg;
            cnt_q       <= '0;
            fields      <= ctl_defaults(strap_speed, strap_aneg, pin_pd);
        end else if (busy) begin
            cnt_q  <= cnt_q - 1'b1;
            fields <= ctl_defaults(strap_spd_q, strap_an_q, pin_pd);
        end else if (wr_hit) begin
            if (wr_srst) begin
                cnt_q  <= CW'(RST_CYCLES);
                fields <= ctl_defaults(strap_spd_q, strap_an_q, pin_pd);
            end else begin
                fields       <= wr_fields;
                fields.pdown <= wr_fields.pdown | pin_pd;
            end
        end else if (pin_pd) begin
            fields.pdown <= 1'b1;
        end
    end

    a_r4_sr_start: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_srst && !busy) |=> busy);

    a_r4_sr_defaults: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!fields.loopback && !fields.isolate && !fields.duplex));

    a_r7_pin_sets_bit: assert property (@(posedge clk) disable iff (rst)
        pin_pd |=> fields.pdown);

endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
    import phy_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_hit,
    input  logic        link_up,
    input  logic        remote_fault,
    input  logic        aneg_done,
    output logic [15:0] word
);
    logic ll_q;
    logic lh_q;
    stat_fields_t s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ll_q <= 1'b0;
            lh_q <= 1'b0;
        end else if (rd_hit) begin
            ll_q <= link_up;
            lh_q <= remote_fault;
        end else begin
            ll_q <= ll_q & link_up;
            lh_q <= lh_q | remote_fault;
        end
    end

    always_comb begin
        s.aneg_done = aneg_done;
        s.rfault_lh = lh_q;
        s.link_ll   = ll_q;
        word        = stat_to_word(s);
    end

    a_r9_lh_hold: assert property (@(posedge clk) disable iff (rst)
        (lh_q && !rd_hit) |=> lh_q);

    a_r9_ll_hold: assert property (@(posedge clk) disable iff (rst)
        (!ll_q && !rd_hit) |=> !ll_q);

endmodule

// File: rtl/phy_vend_reg.sv
module phy_vend_reg #(
    parameter int VEVT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_scr,
    input  logic              rd_evt,
    input  logic [15:0]       wr_data,
    input  logic [VEVT_W-1:0] evt_in,
    output logic [15:0]       scratch,
    output logic [15:0]       evt_word
);
    logic [VEVT_W-1:0] evt_q;

    always_ff @(posedge clk) begin
        if (rst)         scratch <= '0;
        else if (wr_scr) scratch <= wr_data;
    end

    for (genvar i = 0; i < VEVT_W; i++) begin : g_cor
        always_ff @(posedge clk) begin
            if (rst)         evt_q[i] <= 1'b0;
            else if (rd_evt) evt_q[i] <= evt_in[i];
            else             evt_q[i] <= evt_q[i] | evt_in[i];
        end
    end

    assign evt_word = 16'(evt_q);

    a_r5_scratch_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_scr |=> $stable(scratch));

    a_r10_cor_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_evt && evt_in == '0) |=> (evt_q == '0));

    a_r10_cor_hold: assert property (@(posedge clk) disable iff (rst)
        (!rd_evt) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          RST_CYCLES = 16,
    parameter int          VEVT_W     = 4,
    parameter logic [15:0] ID_WORD    = 16'h5A31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    input  logic              strap_speed,
    input  logic              strap_aneg,
    input  logic              pwdn_pin_n,
    input  logic              link_up,
    input  logic              remote_fault,
    input  logic              aneg_done,
    input  logic [VEVT_W-1:0] vend_evt,
    output logic              ctl_soft_reset,
    output logic              ctl_loopback,
    output logic              ctl_isolate,
    output logic              ctl_power_down,
    output logic              ctl_aneg_en,
    output logic              ctl_speed100,
    output logic              ctl_full_duplex
);
    rsel_e       sel;
    ctl_fields_t cf;
    logic        busy;
    logic        pin_pd;
    logic [15:0] stat_word;
    logic [15:0] scr_word;
    logic [15:0] vevt_word;
    logic [15:0] rd_mux;

    always_comb begin
        if      (addr == ADDR_W'(A_CTL))  sel = SEL_CTL;
        else if (addr == ADDR_W'(A_STAT)) sel = SEL_STAT;
        else if (addr == ADDR_W'(A_ID))   sel = SEL_ID;
        else if (addr == ADDR_W'(A_SCR))  sel = SEL_SCR;
        else if (addr == ADDR_W'(A_VEVT)) sel = SEL_VEVT;
        else                              sel = SEL_NONE;
    end

    assign pin_pd = ~pwdn_pin_n;

    phy_ctl_reg #(.RST_CYCLES(RST_CYCLES)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .wr_hit      (wr_en && sel == SEL_CTL),
        .wr_srst     (wr_data[B_SRST]),
        .wr_fields   (ctl_from_word(wr_data)),
        .strap_speed (strap_speed),
        .strap_aneg  (strap_aneg),
        .pin_pd      (pin_pd),
        .fields      (cf),
        .busy        (busy)
    );

    phy_stat_reg u_stat (
        .clk          (clk),
        .rst          (rst),
        .rd_hit       (rd_en && sel == SEL_STAT),
        .link_up      (link_up),
        .remote_fault (remote_fault),
        .aneg_done    (aneg_done),
        .word         (stat_word)
    );

    phy_vend_reg #(.VEVT_W(VEVT_W)) u_vend (
        .clk      (clk),
        .rst      (rst),
        .wr_scr   (wr_en && sel == SEL_SCR),
        .rd_evt   (rd_en && sel == SEL_VEVT),
        .wr_data  (wr_data),
        .evt_in   (vend_evt),
        .scratch  (scr_word),
        .evt_word (vevt_word)
    );

    always_comb begin
        unique case (sel)
            SEL_CTL:  rd_mux = ctl_to_word(busy, cf);
            SEL_STAT: rd_mux = stat_word;
            SEL_ID:   rd_mux = ID_WORD;
            SEL_SCR:  rd_mux = scr_word;
            SEL_VEVT: rd_mux = vevt_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign ctl_soft_reset  = busy;
    assign ctl_loopback    = cf.loopback;
    assign ctl_isolate     = cf.isolate;
    assign ctl_aneg_en     = cf.aneg_en;
    assign ctl_power_down  = cf.pdown | pin_pd;
    assign ctl_speed100    = ~cf.aneg_en & cf.speed100;
    assign ctl_full_duplex = ~cf.aneg_en & cf.duplex;

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rd_data == 16'h0000));

    a_r13_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    a_r6_forced_gate: assert property (@(posedge clk) disable iff (rst)
        ctl_aneg_en |-> (!ctl_speed100 && !ctl_full_duplex));

endmodule

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
    localparam int          AW    = 5;
    localparam int          RSTC  = 16;
    localparam int          VW    = 4;
    localparam logic [15:0] IDW   = 16'h5A31;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic [15:0]   wr_data;
    logic          rd_en;
    logic [15:0]   rd_data;
    logic          strap_speed, strap_aneg, pwdn_pin_n;
    logic          link_up, remote_fault, aneg_done;
    logic [VW-1:0] vend_evt;
    logic          ctl_soft_reset, ctl_loopback, ctl_isolate, ctl_power_down;
    logic          ctl_aneg_en, ctl_speed100, ctl_full_duplex;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    phy_mgmt_regs #(.ADDR_W(AW), .RST_CYCLES(RSTC), .VEVT_W(VW), .ID_WORD(IDW)) u_phy_mgmt_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .strap_speed(strap_speed), .strap_aneg(strap_aneg),
        .pwdn_pin_n(pwdn_pin_n), .link_up(link_up), .remote_fault(remote_fault),
        .aneg_done(aneg_done), .vend_evt(vend_evt), .ctl_soft_reset(ctl_soft_reset),
        .ctl_loopback(ctl_loopback), .ctl_isolate(ctl_isolate), .ctl_power_down(ctl_power_down),
        .ctl_aneg_en(ctl_aneg_en), .ctl_speed100(ctl_speed100), .ctl_full_duplex(ctl_full_duplex)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: pops one expected word per sampled read strobe
    always @(posedge clk) begin
        logic fire;
        fire = rd_en && !rst;
        #1;
        if (fire) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R13: unexpected read, actual %h expected none", rd_data);
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic ctl_outs(input logic [6:0] exp, input string tag);
        check(16'({ctl_soft_reset, ctl_loopback, ctl_isolate, ctl_power_down,
                   ctl_aneg_en, ctl_speed100, ctl_full_duplex}), 16'(exp), tag);
    endtask

    task automatic pulse_link_down();
        link_up = 1'b0; @(negedge clk); link_up = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr = '0; wr_en = 0; wr_data = '0; rd_en = 0;
        strap_speed = 1; strap_aneg = 1; pwdn_pin_n = 1;
        link_up = 1; remote_fault = 0; aneg_done = 0; vend_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state; order: srst,loop,iso,pd,aneg,spd100,fdx
        ctl_outs(7'b0000100, "R1 outputs after reset");
        rd(AW'('h00), 16'h3000, "R1 control reset value");
        rd(AW'('h02), IDW, "R11 id word");
        rd(AW'('h05), 16'h0000, "R12 unmapped read");

        // R8/R9 latched-low starts 0, reloads on read
        rd(AW'('h01), 16'h7001, "R8 status first read");
        rd(AW'('h01), 16'h7005, "R9 link reloaded");

        // R3/R6 read/write control bits and forced outputs
        wr(AW'('h00), 16'h4500);
        rd(AW'('h00), 16'h4500, "R3 loop iso dup");
        ctl_outs(7'b0110001, "R6 forced dup only");
        wr(AW'('h00), 16'h2100);
        ctl_outs(7'b0000011, "R6 forced 100 full");
        wr(AW'('h00), 16'h3100);
        ctl_outs(7'b0000100, "R6 aneg gates forced");
        wr(AW'('h00), 16'h02FF);
        rd(AW'('h00), 16'h0000, "R3 unused bits read 0");

        // R11 / R8 writes ignored
        wr(AW'('h02), 16'hFFFF);
        rd(AW'('h02), IDW, "R11 id after write");
        wr(AW'('h01), 16'h0000);
        rd(AW'('h01), 16'h7005, "R8 status after write");

        // R9 latched high
        remote_fault = 1; @(negedge clk); remote_fault = 0;
        rd(AW'('h01), 16'h7015, "R9 remote fault held");
        rd(AW'('h01), 16'h7005, "R9 remote fault released");
        // R9 latched low
        pulse_link_down();
        rd(AW'('h01), 16'h7001, "R9 link low held");
        rd(AW'('h01), 16'h7005, "R9 link low released");
        // R9 event coincident with read is kept
        link_up = 1'b0;
        rd(AW'('h01), 16'h7005, "R9 coincident read old");
        link_up = 1'b1;
        rd(AW'('h01), 16'h7001, "R9 coincident event kept");
        rd(AW'('h01), 16'h7005, "R9 after coincident");
        // R8 live event bit
        aneg_done = 1;
        rd(AW'('h01), 16'h7025, "R8 aneg done live");
        aneg_done = 0;
        rd(AW'('h01), 16'h7005, "R8 aneg done gone");

        // R10 clear on read
        vend_evt = 4'b0101; @(negedge clk); vend_evt = '0;
        rd(AW'('h11), 16'h0005, "R10 cor returns events");
        rd(AW'('h11), 16'h0000, "R10 cor cleared");
        vend_evt = 4'b0010;
        rd(AW'('h11), 16'h0000, "R10 coincident read old");
        vend_evt = '0;
        rd(AW'('h11), 16'h0002, "R10 coincident event kept");
        rd(AW'('h11), 16'h0000, "R10 cleared again");

        // R12 unmapped read has no side effect
        vend_evt = 4'b0001; @(negedge clk); vend_evt = '0;
        remote_fault = 1; @(negedge clk); remote_fault = 0;
        rd(AW'('h05), 16'h0000, "R12 unmapped 05");
        rd(AW'('h1F), 16'h0000, "R12 unmapped 1F");
        rd(AW'('h11), 16'h0001, "R12 cor kept");
        rd(AW'('h01), 16'h7015, "R12 latch kept");

        // R4/R5 software reset
        wr(AW'('h10), 16'hA5C3);
        vend_evt = 4'b1000; @(negedge clk); vend_evt = '0;
        wr(AW'('h00), 16'h4400);
        wr(AW'('h00), 16'h8000);               // edge E0
        rd(AW'('h00), 16'hB000, "R4 busy first");   // E1
        wr(AW'('h00), 16'h4000);               // E2, ignored
        ctl_outs(7'b1000100, "R4 soft reset output");
        repeat (13) @(negedge clk);
        rd(AW'('h00), 16'hB000, "R4 busy last edge");   // E16
        rd(AW'('h00), 16'h3000, "R4 done defaults");    // E17
        rd(AW'('h10), 16'hA5C3, "R5 scratch kept");
        rd(AW'('h11), 16'h0008, "R5 vendor event kept");

        // R2 straps low at hardware reset, reload after soft reset
        strap_speed = 0; strap_aneg = 0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        strap_speed = 1; strap_aneg = 1;
        rd(AW'('h00), 16'h0000, "R2 strap low defaults");
        wr(AW'('h00), 16'h6000);
        rd(AW'('h00), 16'h6000, "R3 speed loop write");
        wr(AW'('h00), 16'h8000);
        repeat (20) @(negedge clk);
        rd(AW'('h00), 16'h0000, "R2 straps reloaded not live");

        // R7 power down
        pwdn_pin_n = 0; #1;
        check(16'(ctl_power_down), 16'h1, "R7 pin drives output");
        @(negedge clk);
        pwdn_pin_n = 1; #1;
        check(16'(ctl_power_down), 16'h1, "R7 bit held after pin");
        rd(AW'('h00), 16'h0800, "R7 pd bit set by pin");
        wr(AW'('h10), 16'h1234);
        rd(AW'('h10), 16'h1234, "R7 access in power down");
        wr(AW'('h00), 16'h0000);
        check(16'(ctl_power_down), 16'h0, "R7 cleared");
        wr(AW'('h00), 16'h0800);
        check(16'(ctl_power_down), 16'h1, "R7 bit drives output");

        // R13 hold between reads
        repeat (3) @(negedge clk);
        check(rd_data, 16'h1234, "R13 rd_data holds");

        if (exp_q.size() != 0) check(16'(exp_q.size()), 16'h0, "R13 pending reads");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule